// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Receiver with Event Pulses

This block receives a sampled HDLC line one bit at a time. A separate strobe marks each valid bit. The block finds flag sequences and removes the zeros that the transmitter inserted. It assembles the remaining bits into bytes, least significant bit first, and presents them on a byte output. Each byte carries a marker that shows when the current fixed-size receive buffer has filled. A frame is made of two address bytes, a control byte, information bytes and two check bytes, with a flag before and after it. The check bytes are passed to the byte output along with the rest of the frame.

Alongside the data, the block raises one-cycle event pulses:
- line idle;
- start of flag reception;
- end of flag reception;
- receive buffer full;
- frame received.

The frame-received pulse carries an error bit for a frame whose 16-bit CRC does not check. It is delayed by a parameter number of cycles after the closing flag, so it can follow the flag pulse of that same flag. Carrier detect is not produced here.

Top module: `hdlc_rx_events`

## Requirements
- R1: While reset is low and after it is released, every output pulse (`byte_vld`, `buf_last`, and all `ev_*` outputs) and `rxf_crc_err` is 0 until line bits arrive.
- R2: A flag is the bit sequence 0,1,1,1,1,1,1,0. `ev_flag_start` pulses on the bit that completes a flag when no flag run is in progress. A further flag completed within 8 bits of the previous one continues the run and gives no pulse.
- R3: `ev_flag_end` pulses on the 8th bit after the last flag of a run, provided that bit does not complete a flag. `ev_flag_start` and `ev_flag_end` never pulse together.
- R4: Inside a frame, a 0 that follows five consecutive 1s is deleted. The remaining bits form bytes, least significant bit first. Each byte appears on `byte_data` with a one-cycle `byte_vld`. The two CRC bytes are output like any other byte.
- R5: A data bit reaches the byte assembler only after seven further frame bits have arrived. As a result, the seven bits in front of a closing flag or an abort never reach the output, and a byte whose last bit is among them is not output.
- R6: Every `BUF_BYTES`-th byte of a frame (default 6) is marked with `buf_last` and `ev_rxb` in the same cycle. The count restarts at every flag.
- R7: A closing flag that ends a frame of at least 5 bytes produces `ev_rxf` exactly `RXF_LAG` cycles (default 2) after that flag's `ev_flag_start` would appear.
  - The CRC is CRC-16 with polynomial 0x1021, processed least significant bit first, with an initial value of 0xFFFF.
  - The transmitter sends the CRC complemented, low byte first.
  - `rxf_crc_err` is 1 with `ev_rxf` when the remainder over the whole frame, CRC bytes included, is not 0xF0B8.
- R8: A frame of fewer than 5 bytes produces no `ev_rxf`.
- R9: Seven consecutive 1s inside a frame abort it. An aborted frame produces no `ev_rxf`, and no data is taken until the next flag.
- R10: `ev_idle` pulses on the 15th consecutive 1 bit. It pulses only once however long the 1s continue, and is re-armed by any 0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | Strobe: `rx_bit` holds a new line bit this cycle |
| rx_bit | input | 1 | Sampled receive line bit |
| byte_vld | output | 1 | One-cycle pulse: `byte_data` holds a received byte |
| byte_data | output | 8 | Received byte |
| buf_last | output | 1 | This byte fills the current receive buffer |
| ev_idle | output | 1 | Line idle event |
| ev_flag_start | output | 1 | Flag reception began |
| ev_flag_end | output | 1 | Flag reception ended |
| ev_rxb | output | 1 | Receive buffer full event |
| ev_rxf | output | 1 | Frame received event |
| rxf_crc_err | output | 1 | CRC check failed for the frame reported by `ev_rxf` |

## Verification
The bench feeds the line with several patterns, and each one separates different behaviour:
- Long runs of 1s, with and without a 0 between them, separate a single idle report from repeated ones and show that a 0 re-arms the event.
- Frames whose contents are full of 0x7E, 0xFF and 0x3F check that zero insertion is undone. Extra opening flags and frames sent back to back check that flags inside one run are not reported again.
- Frames of 13, 5 and 6 bytes place the buffer boundary on a data byte and on the last CRC byte.
- A frame with a corrupted CRC byte, a 4-byte frame and an abort after three bytes separate the error report, the silent discard and the loss of the bytes still held back. A clean frame that follows the abort checks that the receiver recovers.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants, types and the bitwise CRC step for the HDLC receiver.
// Assumes bytes travel least significant bit first on the line.
package hdlc_rx_pkg;
    localparam logic [7:0]  FLAG_PAT  = 8'h7E;
    localparam int          PEND_BITS = $bits(FLAG_PAT) - 1;
    localparam int          STUFF_RUN = 5;
    localparam int          FLAG_RUN  = 6;
    localparam logic [15:0] CRC_POLY_LSB = 16'h8408;   // 0x1021, bit reversed
    localparam logic [15:0] CRC_INIT     = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD     = 16'hF0B8;

    // Per-bit decision from the line stage to the byte stage.
    typedef struct packed {
        logic flag;
        logic abort;
        logic dvld;
        logic dbit;
    } line_ev_t;

    // One CRC step, least significant bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY_LSB : 16'h0000);
    endfunction
endpackage

// File: rtl/hdlc_rx_linebits.sv
// Line stage: watches raw bits for flags, aborts and inserted zeros. It
// classifies each bit for the byte stage and raises the idle and flag events.
// Assumes IDLE_ONES > FLAG_RUN, so the ones counter can reach the abort count.
module hdlc_rx_linebits
    import hdlc_rx_pkg::*;
#(
    parameter int IDLE_ONES = 15
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_vld,
    input  logic     rx_bit,
    output line_ev_t lev,
    output logic     ev_idle,
    output logic     ev_flag_start,
    output logic     ev_flag_end
);
    localparam int OW = $clog2(IDLE_ONES + 1);

    logic [6:0]    win_q;
    logic [7:0]    win_n;
    logic [OW-1:0] ones_q;
    logic          synced_q;
    logic          run_q;
    logic [2:0]    rcnt_q;
    logic          stuff;

    // Classify the current bit: flag, abort, inserted zero or data.
    always_comb begin
        win_n     = {win_q, rx_bit};
        lev.flag  = bit_vld && (win_n == FLAG_PAT);
        lev.abort = bit_vld && synced_q && rx_bit && (ones_q == OW'(FLAG_RUN));
        stuff     = synced_q && !rx_bit && (ones_q == OW'(STUFF_RUN));
        lev.dvld  = bit_vld && synced_q && !lev.flag && !lev.abort && !stuff;
        lev.dbit  = rx_bit;
    end

    // Track the bit window, the run of ones, sync and the flag run; raise events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q         <= '1;
            ones_q        <= '0;
            synced_q      <= 1'b0;
            run_q         <= 1'b0;
            rcnt_q        <= '0;
            ev_idle       <= 1'b0;
            ev_flag_start <= 1'b0;
            ev_flag_end   <= 1'b0;
        end else begin
            ev_idle       <= 1'b0;
            ev_flag_start <= 1'b0;
            ev_flag_end   <= 1'b0;
            if (bit_vld) begin
                win_q <= win_n[6:0];
                if (!rx_bit) begin
                    ones_q <= '0;
                end else if (ones_q != OW'(IDLE_ONES)) begin
                    ones_q <= ones_q + 1'b1;
                end
                ev_idle <= rx_bit && (ones_q == OW'(IDLE_ONES - 1));
                if (lev.flag) begin
                    synced_q <= 1'b1;
                end else if (lev.abort) begin
                    synced_q <= 1'b0;
                end
                if (lev.flag) begin
                    ev_flag_start <= !run_q;
                    run_q         <= 1'b1;
                    rcnt_q        <= '0;
                end else if (run_q) begin
                    rcnt_q <= rcnt_q + 1'b1;
                    if (rcnt_q == 3'd7) begin
                        ev_flag_end <= 1'b1;
                        run_q       <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_assemble.sv
// Byte stage: holds back PEND_BITS data bits so that a flag's leading bits are
// never stored. It assembles bytes least significant bit first, runs the CRC,
// counts bytes into fixed-size buffers and judges the frame at its closing flag.
// Assumes BUF_BYTES >= 2.
module hdlc_rx_assemble
    import hdlc_rx_pkg::*;
#(
    parameter int BUF_BYTES = 6,
    parameter int MIN_BYTES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  line_ev_t   lev,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       buf_last,
    output logic       ev_rxb,
    output logic       frame_done,
    output logic       frame_bad
);
    localparam int BW = $clog2(BUF_BYTES);
    localparam int MW = $clog2(MIN_BYTES + 1);
    localparam logic [2:0] PEND_FULL = 3'(PEND_BITS);

    logic [PEND_BITS-1:0] pend_q;
    logic [2:0]           pend_n_q;
    logic [6:0]           acc_q;
    logic [2:0]           bcnt_q;
    logic [15:0]          crc_q;
    logic [MW-1:0]        nbytes_q;
    logic [BW-1:0]        bufc_q;
    logic                 out_vld;
    logic                 ob;

    // The oldest held bit leaves the holding line when a new data bit enters a full line.
    always_comb begin
        out_vld = lev.dvld && (pend_n_q == PEND_FULL);
        ob      = pend_q[0];
    end

    // Shift data, build bytes, update CRC and counters; close or drop frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_n_q   <= '0;
            acc_q      <= '0;
            bcnt_q     <= '0;
            crc_q      <= CRC_INIT;
            nbytes_q   <= '0;
            bufc_q     <= '0;
            byte_vld   <= 1'b0;
            byte_data  <= '0;
            buf_last   <= 1'b0;
            ev_rxb     <= 1'b0;
            frame_done <= 1'b0;
            frame_bad  <= 1'b0;
        end else begin
            byte_vld   <= 1'b0;
            buf_last   <= 1'b0;
            ev_rxb     <= 1'b0;
            frame_done <= 1'b0;
            if (lev.flag || lev.abort) begin
                if (lev.flag) begin
                    frame_done <= (nbytes_q >= MW'(MIN_BYTES));
                    frame_bad  <= (crc_q != CRC_GOOD);
                end
                pend_n_q <= '0;
                acc_q    <= '0;
                bcnt_q   <= '0;
                crc_q    <= CRC_INIT;
                nbytes_q <= '0;
                bufc_q   <= '0;
            end else if (lev.dvld) begin
                pend_q <= {lev.dbit, pend_q[PEND_BITS-1:1]};
                if (pend_n_q != PEND_FULL) begin
                    pend_n_q <= pend_n_q + 1'b1;
                end
                if (out_vld) begin
                    crc_q  <= crc_step(crc_q, ob);
                    acc_q  <= {ob, acc_q[6:1]};
                    bcnt_q <= bcnt_q + 1'b1;
                    if (bcnt_q == 3'd7) begin
                        byte_vld  <= 1'b1;
                        byte_data <= {ob, acc_q};
                        if (nbytes_q != MW'(MIN_BYTES)) begin
                            nbytes_q <= nbytes_q + 1'b1;
                        end
                        if (bufc_q == BW'(BUF_BYTES - 1)) begin
                            buf_last <= 1'b1;
                            ev_rxb   <= 1'b1;
                            bufc_q   <= '0;
                        end else begin
                            bufc_q <= bufc_q + 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_lag.sv
// Delays the frame-received pulse and its error bit by LAG cycles, standing in
// for the latency of the receive FIFO. LAG = 0 passes them straight through.
module hdlc_rx_lag #(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_err,
    output logic out_vld,
    output logic out_err
);
    generate
        if (LAG == 0) begin : g_pass
            assign out_vld = in_vld;
            assign out_err = in_vld & in_err;
        end else if (LAG == 1) begin : g_one
            logic v_q, e_q;
            // Single delay stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    e_q <= 1'b0;
                end else begin
                    v_q <= in_vld;
                    e_q <= in_vld & in_err;
                end
            end
            assign out_vld = v_q;
            assign out_err = e_q;
        end else begin : g_many
            logic [LAG-1:0] v_q, e_q;
            // Shift chain of LAG stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= '0;
                    e_q <= '0;
                end else begin
                    v_q <= {v_q[LAG-2:0], in_vld};
                    e_q <= {e_q[LAG-2:0], in_vld & in_err};
                end
            end
            assign out_vld = v_q[LAG-1];
            assign out_err = e_q[LAG-1];
        end
    endgenerate
endmodule

// File: rtl/hdlc_rx_events.sv
// Top of the bit-serial HDLC receiver. It joins the line stage, the byte stage
// and the frame-event delay. Assumes at most one line bit per clock cycle,
// marked by bit_vld.
module hdlc_rx_events
    import hdlc_rx_pkg::*;
#(
    parameter int BUF_BYTES = 6,
    parameter int MIN_BYTES = 5,
    parameter int IDLE_ONES = 15,
    parameter int RXF_LAG   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       rx_bit,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       buf_last,
    output logic       ev_idle,
    output logic       ev_flag_start,
    output logic       ev_flag_end,
    output logic       ev_rxb,
    output logic       ev_rxf,
    output logic       rxf_crc_err
);
    line_ev_t lev;
    logic     frame_done;
    logic     frame_bad;

    hdlc_rx_linebits #(.IDLE_ONES(IDLE_ONES)) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld      (bit_vld),
        .rx_bit       (rx_bit),
        .lev          (lev),
        .ev_idle      (ev_idle),
        .ev_flag_start(ev_flag_start),
        .ev_flag_end  (ev_flag_end)
    );

    hdlc_rx_assemble #(.BUF_BYTES(BUF_BYTES), .MIN_BYTES(MIN_BYTES)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lev       (lev),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .buf_last  (buf_last),
        .ev_rxb    (ev_rxb),
        .frame_done(frame_done),
        .frame_bad (frame_bad)
    );

    hdlc_rx_lag #(.LAG(RXF_LAG)) u_lag (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (frame_done),
        .in_err (frame_bad),
        .out_vld(ev_rxf),
        .out_err(rxf_crc_err)
    );
endmodule

// File: rtl/hdlc_rx_events_chk.sv
// Port-level properties of the HDLC receiver, bound to the top module.
module hdlc_rx_events_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       byte_vld,
    input logic       buf_last,
    input logic       ev_idle,
    input logic       ev_flag_start,
    input logic       ev_flag_end,
    input logic       ev_rxb,
    input logic       ev_rxf,
    input logic       rxf_crc_err
);
    a_r6_rxb_marks_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rxb |-> (byte_vld && buf_last));
    a_r6_last_needs_rxb: assert property (@(posedge clk) disable iff (!rst_n)
        buf_last |-> ev_rxb);
    a_r7_err_needs_rxf: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_crc_err |-> ev_rxf);
    a_r10_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
        ev_idle |=> !ev_idle);
    a_r3_flag_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_flag_start && ev_flag_end));
    a_r4_byte_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(bit_vld));
    a_r2_line_events_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_flag_start || ev_flag_end || ev_idle) |-> $past(bit_vld));
    a_r5_no_byte_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flag_start |-> !byte_vld);
endmodule

bind hdlc_rx_events hdlc_rx_events_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_vld      (bit_vld),
    .byte_vld     (byte_vld),
    .buf_last     (buf_last),
    .ev_idle      (ev_idle),
    .ev_flag_start(ev_flag_start),
    .ev_flag_end  (ev_flag_end),
    .ev_rxb       (ev_rxb),
    .ev_rxf       (ev_rxf),
    .rxf_crc_err  (rxf_crc_err)
);

// File: tb/tb_hdlc_rx_events.sv
// Scoreboard bench: driver tasks queue the expected bytes and events, and a
// monitor pops and compares them as the receiver produces them.
module tb_hdlc_rx_events;
    localparam int BUF     = 6;
    localparam int LAG     = 2;
    localparam int EV_IDLE = 1;
    localparam int EV_FS   = 2;
    localparam int EV_FE   = 3;
    localparam int EV_RXB  = 4;
    localparam int EV_OK   = 5;
    localparam int EV_ERR  = 6;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       rx_bit = 1'b1;
    logic       byte_vld, buf_last, ev_idle, ev_flag_start, ev_flag_end;
    logic       ev_rxb, ev_rxf, rxf_crc_err;
    logic [7:0] byte_data;

    int checks = 0, fails = 0, cyc = 0, last_fs = 0;
    int rxf_seen = 0, bytes_seen = 0, idle_seen = 0, tb_ones = 0;
    bit done = 1'b0;
    int       ev_q[$];
    logic [8:0] b_q[$];

    always #2 clk = ~clk;

    hdlc_rx_events #(.BUF_BYTES(BUF), .RXF_LAG(LAG)) dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
        .byte_vld(byte_vld), .byte_data(byte_data), .buf_last(buf_last),
        .ev_idle(ev_idle), .ev_flag_start(ev_flag_start), .ev_flag_end(ev_flag_end),
        .ev_rxb(ev_rxb), .ev_rxf(ev_rxf), .rxf_crc_err(rxf_crc_err)
    );

    function automatic string req_of(input int code);
        case (code)
            EV_IDLE: return "R10";
            EV_FS:   return "R2";
            EV_FE:   return "R3";
            EV_RXB:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic got_ev(input int code);
        if (ev_q.size() == 0) check(1'b0, req_of(code), code, 0);
        else begin
            int e;
            e = ev_q.pop_front();
            check(e == code, req_of(e), code, e);
        end
    endtask

    // Monitor: compare outputs against the queued expectations.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            if (byte_vld) begin
                bytes_seen++;
                if (b_q.size() == 0) check(1'b0, "R4", int'({buf_last, byte_data}), -1);
                else begin
                    logic [8:0] eb;
                    eb = b_q.pop_front();
                    check({buf_last, byte_data} == eb, "R4", int'({buf_last, byte_data}), int'(eb));
                end
            end
            if (ev_idle) begin idle_seen++; got_ev(EV_IDLE); end
            if (ev_flag_start) begin last_fs = cyc; got_ev(EV_FS); end
            if (ev_flag_end) got_ev(EV_FE);
            if (ev_rxb) got_ev(EV_RXB);
            if (ev_rxf) begin
                rxf_seen++;
                got_ev(rxf_crc_err ? EV_ERR : EV_OK);
                check(cyc - last_fs == LAG, "R7", cyc - last_fs, LAG);
            end
        end
    end

    task automatic put_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        rx_bit  = b;
        @(negedge clk);
        bit_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) put_bit(1'b1);
    endtask

    task automatic send_flag();
        put_bit(1'b0);
        send_ones(6);
        put_bit(1'b0);
        tb_ones = 0;
    endtask

    // Send one byte LSB first, inserting a zero after five ones.
    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            put_bit(v[i]);
            tb_ones = v[i] ? tb_ones + 1 : 0;
            if (tb_ones == 5) begin
                put_bit(1'b0);
                tb_ones = 0;
            end
        end
    endtask

    function automatic logic [15:0] crc_ref(input bq_t d);
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (d[i]) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ d[i][k];
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic send_frame(input bq_t d, input int nflags, input bit in_run, input bit bad);
        bq_t all;
        logic [15:0] fcs;
        all = d;
        fcs = ~crc_ref(d);
        all.push_back(fcs[7:0] ^ {7'd0, bad});
        all.push_back(fcs[15:8]);
        if (!in_run) ev_q.push_back(EV_FS);
        ev_q.push_back(EV_FE);
        foreach (all[i]) begin
            bit last;
            last = ((i + 1) % BUF) == 0;
            b_q.push_back({last, all[i]});
            if (last) ev_q.push_back(EV_RXB);
        end
        ev_q.push_back(EV_FS);
        if (all.size() >= 5) ev_q.push_back(bad ? EV_ERR : EV_OK);
        for (int i = 0; i < nflags; i++) send_flag();
        foreach (all[i]) send_byte(all[i]);
        send_flag();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1: watchdog actual %0d expected 0", cyc);
            finish_run();
        end
    end

    initial begin
        int r0, b0;
        repeat (4) @(negedge clk);
        // R1: quiet outputs in and after reset
        check({byte_vld, buf_last, ev_idle, ev_flag_start, ev_flag_end, ev_rxb, ev_rxf, rxf_crc_err} == 0,
              "R1", int'({byte_vld, ev_idle, ev_flag_start, ev_flag_end, ev_rxb, ev_rxf}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({byte_vld, buf_last, ev_idle, ev_flag_start, ev_flag_end, ev_rxb, ev_rxf, rxf_crc_err} == 0,
              "R1", int'({byte_vld, ev_idle, ev_flag_start, ev_flag_end, ev_rxb, ev_rxf}), 0);

        // R10: one idle event per run of ones, re-armed by a zero
        ev_q.push_back(EV_IDLE);
        send_ones(20);
        check(idle_seen == 1, "R10", idle_seen, 1);
        put_bit(1'b0);
        ev_q.push_back(EV_IDLE);
        send_ones(15);
        check(idle_seen == 2, "R10", idle_seen, 2);

        // R4 R6 R7: stuffing-heavy 13-byte frame, then back-to-back frames
        send_frame('{8'h7E, 8'hFF, 8'h03, 8'h3F, 8'hF8, 8'h00, 8'hA5, 8'h5A,
                     8'hFF, 8'hFE, 8'h81}, 2, 1'b0, 1'b0);
        send_frame('{8'h10, 8'h20, 8'h30}, 0, 1'b1, 1'b0);
        send_frame('{8'h11, 8'h22, 8'h33, 8'h44}, 0, 1'b1, 1'b1);
        ev_q.push_back(EV_FE);
        ev_q.push_back(EV_IDLE);
        send_ones(16);

        // R8: four-byte frame gives no frame event
        r0 = rxf_seen;
        send_frame('{8'hAB, 8'hCD}, 1, 1'b0, 1'b0);
        ev_q.push_back(EV_FE);
        ev_q.push_back(EV_IDLE);
        send_ones(16);
        check(rxf_seen == r0, "R8", rxf_seen - r0, 0);

        // R9 R5: abort after three bytes; the third byte is still held back
        r0 = rxf_seen;
        b0 = bytes_seen;
        ev_q.push_back(EV_FS);
        ev_q.push_back(EV_FE);
        b_q.push_back({1'b0, 8'h55});
        b_q.push_back({1'b0, 8'hA3});
        send_flag();
        send_byte(8'h55);
        send_byte(8'hA3);
        send_byte(8'h12);
        ev_q.push_back(EV_IDLE);
        send_ones(15);
        repeat (10) @(negedge clk);
        check(rxf_seen == r0, "R9", rxf_seen - r0, 0);
        check(bytes_seen - b0 == 2, "R5", bytes_seen - b0, 2);

        // R6 R9: recovery; the buffer fills on the last CRC byte
        send_frame('{8'hC3, 8'h11, 8'h22, 8'h7F}, 1, 1'b0, 1'b0);
        ev_q.push_back(EV_FE);
        ev_q.push_back(EV_IDLE);
        send_ones(16);
        repeat (20) @(negedge clk);

        check(ev_q.size() == 0, "R2", ev_q.size(), 0);
        check(b_q.size() == 0, "R4", b_q.size(), 0);
        check(rxf_seen == 4, "R7", rxf_seen, 4);
        done = 1'b1;
        finish_run();
    end
endmodule